// File: doc/BRIEF.md
# Serial Configuration Memory Readout Controller

This block is the read side of a bit-serial configuration store that an SRAM FPGA clocks out at power-up. A one-bit-wide array of `DEPTH` entries holds the bitstream. It is filled through a simple synchronous write port. A bit address counter walks through the array, advancing once per rising edge of the configuration clock. The addressed bit is presented on a serial data output that can be tri-stated. Here the tri-state output is modelled as a data signal plus an output-enable signal.

Readout is gated by an active-low chip select and a shared reset/output-enable pin. The sense of the shared pin is chosen by a polarity input. With the polarity input at 0, a low level on the pin means reset and a high level means output enable. With the polarity input at 1, the two levels swap.

When the final bit has been shipped, an active-low cascade output asserts and the data line is released. A following device in a chain can then take over the line. A synchronous power-on reset input clears the counter, just as any reset pulse on the shared pin does. After a reset the bitstream can be read out again from address zero.

Top module: `cfgrom_reader`

## Requirements
- R1: While the shared pin is at its reset level, `dataOe` is 0 whatever `ceN` is. Every rising clock edge seen in that state clears the address to 0 and deasserts the cascade output (`casEnN` = 1).
- R2: With the pin at its enable level and `ceN` = 1, `dataOe` is 0 and the address does not change across clock edges.
- R3: With the pin at its enable level, `ceN` = 0 and the last bit not yet sent, `dataOe` is 1 and `dataOut` equals the array bit at the current address. This holds combinationally, so bit 0 is valid as soon as output is enabled. Each rising edge advances the address by one.
- R4: A rising edge that advances past address `DEPTH-1` drives `casEnN` to 0, and from then on `dataOe` is 0.
- R5: Once `casEnN` is 0 it stays 0, and the address holds, through any number of further clocks, until a reset occurs.
- R6: While `porRst` = 1, `dataOe` is 0. Each rising edge in that state clears the address to 0 and sets `casEnN` to 1.
- R7: With `resetPolInv` = 0, `rstOe` = 0 means reset and `rstOe` = 1 means enable. With `resetPolInv` = 1, `rstOe` = 1 means reset and `rstOe` = 0 means enable.
- R8: A reset on the shared pin at any point, including mid-stream or after the cascade output has asserted, restarts readout at bit 0.
- R9: A rising edge with `loadEn` = 1 stores `loadBit` at array address `loadAddr`. Later readout of that address returns the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; the counter advances on its rising edge |
| porRst | input | 1 | Synchronous power-on reset, active high |
| resetPolInv | input | 1 | 0: pin low = reset; 1: pin high = reset |
| rstOe | input | 1 | Shared reset / output-enable pin |
| ceN | input | 1 | Chip select, active low |
| loadEn | input | 1 | Array write strobe |
| loadAddr | input | ADDR_W | Array write address |
| loadBit | input | 1 | Array write data |
| dataOut | output | 1 | Serial data bit (0 when not driven) |
| dataOe | output | 1 | Serial data output enable |
| casEnN | output | 1 | Cascade enable to the next device, active low |

## Verification
The embedded properties assume that `rstOe`, `ceN`, `resetPolInv` and the load inputs are synchronous to `clk` and stable around each rising edge. They also assume that `porRst` is high from time zero for at least one edge and that `loadAddr` stays below `DEPTH`. The bench changes every input only just after a falling edge and draws load addresses only from the valid range. Its random phase mixes chip-select dropouts, shared-pin resets and polarity flips, and it runs long enough to reach the terminal count several times.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;

  // Strobes from the control FSM into the datapath.
  typedef struct packed {
    logic clearAddr;  // zero the bit address on this edge
    logic stepAddr;   // advance the bit address on this edge
    logic driveOut;   // present the addressed bit on the data line
  } ctlStrobe_t;

  // Decode the shared pin into a reset request under the chosen sense.
  function automatic logic resetAsserted(input logic pinLevel, input logic polInv);
    return polInv ? pinLevel : ~pinLevel;
  endfunction

endpackage

// File: rtl/cfgrom_ctrl.sv
module cfgrom_ctrl
  import cfgrom_pkg::*;
(
  input  logic       clk,
  input  logic       porRst,
  input  logic       resetPolInv,
  input  logic       rstOe,
  input  logic       ceN,
  input  logic       atLast,
  output ctlStrobe_t strobe,
  output logic       casEnN
);

  logic pinReset;
  logic chipSel;
  logic doneQ;

  assign pinReset = resetAsserted(rstOe, resetPolInv);
  assign chipSel  = ~ceN;

  always_comb begin
    strobe.clearAddr = porRst | pinReset;
    strobe.stepAddr  = ~strobe.clearAddr & chipSel & ~doneQ;
    strobe.driveOut  = ~strobe.clearAddr & chipSel & ~doneQ;
  end

  // Terminal-count flag: set when the last bit is consumed, held until a reset.
  always_ff @(posedge clk) begin
    if (strobe.clearAddr) begin
      doneQ <= 1'b0;
    end else if (strobe.stepAddr && atLast) begin
      doneQ <= 1'b1;
    end
  end

  assign casEnN = ~doneQ;

  // R4: consuming the last bit hands the line to the next device
  a_r4_cascade_on_last: assert property (@(posedge clk) disable iff (porRst)
    strobe.stepAddr && atLast |=> !casEnN);

  // R5: cascade stays asserted until a reset
  a_r5_cascade_sticky: assert property (@(posedge clk) disable iff (porRst)
    !casEnN && !strobe.clearAddr |=> !casEnN);

  // R1: a pin reset releases the cascade output on the next edge
  a_r1_reset_releases: assert property (@(posedge clk) disable iff (porRst)
    strobe.clearAddr |=> casEnN);

  // R7: default sense, pin low never drives the data line
  a_r7_default_sense: assert property (@(posedge clk) disable iff (porRst)
    (!resetPolInv && !rstOe) |-> !strobe.driveOut);

  // R7: inverted sense, pin high never drives the data line
  a_r7_inverted_sense: assert property (@(posedge clk) disable iff (porRst)
    (resetPolInv && rstOe) |-> !strobe.driveOut);

  // R6: power-on reset clears the terminal flag
  a_r6_por_clears_done: assert property (@(posedge clk)
    porRst |=> casEnN);

endmodule

// File: rtl/cfgrom_datapath.sv
module cfgrom_datapath
  import cfgrom_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              porRst,
  input  ctlStrobe_t        strobe,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic              loadBit,
  output logic              atLast,
  output logic              dataOut,
  output logic              dataOe
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
  localparam logic [ADDR_W-1:0] ONE_ADDR  = ADDR_W'(1);

  logic [DEPTH-1:0]  memBits;
  logic [ADDR_W-1:0] addrQ;

  // One-bit-wide bitstream store, written through the load port.
  always_ff @(posedge clk) begin
    if (loadEn) begin
      memBits[loadAddr] <= loadBit;
    end
  end

  // Bit address counter; it stops at the last address, never wraps.
  always_ff @(posedge clk) begin
    if (strobe.clearAddr) begin
      addrQ <= '0;
    end else if (strobe.stepAddr && !atLast) begin
      addrQ <= addrQ + ONE_ADDR;
    end
  end

  assign atLast  = (addrQ == LAST_ADDR);
  assign dataOe  = strobe.driveOut;
  assign dataOut = strobe.driveOut ? memBits[addrQ] : 1'b0;

  // R3: each enabled edge advances the address by one
  a_r3_step_by_one: assert property (@(posedge clk) disable iff (porRst)
    strobe.stepAddr && !atLast |=> addrQ == $past(addrQ) + ONE_ADDR);

  // R2: with no strobe the address holds
  a_r2_addr_holds: assert property (@(posedge clk) disable iff (porRst)
    !strobe.stepAddr && !strobe.clearAddr |=> $stable(addrQ));

  // R1: a pin reset zeroes the address
  a_r1_addr_cleared: assert property (@(posedge clk) disable iff (porRst)
    strobe.clearAddr |=> addrQ == '0);

  // R5: the address never runs past the end of the array
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (porRst)
    atLast && !strobe.clearAddr |=> atLast);

  // R6: power-on reset zeroes the address
  a_r6_por_clears_addr: assert property (@(posedge clk)
    porRst |=> addrQ == '0);

endmodule

// File: rtl/cfgrom_reader.sv
module cfgrom_reader
  import cfgrom_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              porRst,
  input  logic              resetPolInv,
  input  logic              rstOe,
  input  logic              ceN,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic              loadBit,
  output logic              dataOut,
  output logic              dataOe,
  output logic              casEnN
);

  ctlStrobe_t strobe;
  logic       atLast;

  cfgrom_ctrl u_ctrl (
    .clk         (clk),
    .porRst      (porRst),
    .resetPolInv (resetPolInv),
    .rstOe       (rstOe),
    .ceN         (ceN),
    .atLast      (atLast),
    .strobe      (strobe),
    .casEnN      (casEnN)
  );

  cfgrom_datapath #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk      (clk),
    .porRst   (porRst),
    .strobe   (strobe),
    .loadEn   (loadEn),
    .loadAddr (loadAddr),
    .loadBit  (loadBit),
    .atLast   (atLast),
    .dataOut  (dataOut),
    .dataOe   (dataOe)
  );

  // R4: a released data line and a driven one never coexist with cascade asserted
  a_r4_no_contention: assert property (@(posedge clk) disable iff (porRst)
    !casEnN |-> !dataOe);

endmodule

// File: tb/cfgrom_reader_tb.sv
`timescale 1ns/1ps
module cfgrom_reader_tb;

  localparam int DEPTH  = 16;
  localparam int ADDR_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic porRst = 1'b1;
  logic resetPolInv = 1'b0;
  logic rstOe = 1'b0;
  logic ceN = 1'b1;
  logic loadEn = 1'b0;
  logic [ADDR_W-1:0] loadAddr = '0;
  logic loadBit = 1'b0;
  logic dataOut, dataOe, casEnN;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference state, derived from the requirements only
  logic [DEPTH-1:0] refMem = '0;
  int  refAddr = 0;
  bit  refDone = 0;

  always #4 clk = ~clk;  // 125 MHz

  cfgrom_reader #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .porRst(porRst), .resetPolInv(resetPolInv), .rstOe(rstOe),
    .ceN(ceN), .loadEn(loadEn), .loadAddr(loadAddr), .loadBit(loadBit),
    .dataOut(dataOut), .dataOe(dataOe), .casEnN(casEnN)
  );

  function automatic bit pinInReset(input logic pol, input logic pin);
    return pol ? pin : !pin;
  endfunction

  function automatic bit expOe();
    return !porRst && !pinInReset(resetPolInv, rstOe) && !ceN && !refDone;
  endfunction

  task automatic checkBit(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0b expected %0b (addr %0d)", tag, what, act, exp, refAddr);
    end
  endtask

  // One clock: check outputs under current inputs, then advance the model.
  task automatic cyc(input string tag);
    bit oe;
    #1;
    oe = expOe();
    checkBit(tag, "dataOe", dataOe, oe);
    checkBit(tag, "dataOut", dataOut, oe ? refMem[refAddr] : 1'b0);
    checkBit(tag, "casEnN", casEnN, !refDone);
    @(posedge clk);
    if (loadEn) refMem[loadAddr] = loadBit;
    if (porRst || pinInReset(resetPolInv, rstOe)) begin
      refAddr = 0;
      refDone = 0;
    end else if (!ceN && !refDone) begin
      if (refAddr == DEPTH - 1) refDone = 1;
      else refAddr++;
    end
    @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    int unused;
    unused = $urandom(32'd24681);
    @(negedge clk);

    // R6: power-on reset with pin and select enabled; load the array meanwhile (R9)
    rstOe = 1'b1; ceN = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      loadEn = 1'b1; loadAddr = ADDR_W'(i); loadBit = 1'($urandom & 1);
      cyc("R6");
    end
    loadEn = 1'b0;
    porRst = 1'b0;

    // R1: pin reset, select active
    rstOe = 1'b0; ceN = 1'b0;
    cyc("R1"); cyc("R1");
    ceN = 1'b1; cyc("R1");

    // R3: full readout, R4/R5: terminal count and extra clocks
    rstOe = 1'b1; ceN = 1'b0;
    for (int i = 0; i < DEPTH; i++) cyc("R3");
    for (int i = 0; i < 4; i++) cyc("R5");
    cyc("R4");

    // R8: reset after terminal count, read again from zero
    rstOe = 1'b0; cyc("R8");
    rstOe = 1'b1;
    for (int i = 0; i < 5; i++) cyc("R8");

    // R2: chip select dropped mid-stream, then resumed
    ceN = 1'b1;
    for (int i = 0; i < 3; i++) cyc("R2");
    ceN = 1'b0;
    for (int i = 0; i < 3; i++) cyc("R2");

    // R8: mid-stream reset with select deasserted
    ceN = 1'b1; rstOe = 1'b0; cyc("R8");
    ceN = 1'b0; rstOe = 1'b1; cyc("R8"); cyc("R8");

    // R7: inverted sense, pin high resets, pin low enables
    resetPolInv = 1'b1; rstOe = 1'b1;
    cyc("R7"); cyc("R7");
    rstOe = 1'b0;
    for (int i = 0; i < DEPTH + 2; i++) cyc("R7");

    // R9: rewrite bit 0 and bit DEPTH-1 while held in reset, then read back
    rstOe = 1'b1;
    loadEn = 1'b1; loadAddr = '0; loadBit = !refMem[0]; cyc("R9");
    loadAddr = ADDR_W'(DEPTH - 1); loadBit = !refMem[DEPTH-1]; cyc("R9");
    loadEn = 1'b0; rstOe = 1'b0;
    for (int i = 0; i < DEPTH + 1; i++) cyc("R9");

    // R3: random mix of select dropouts, pin resets and polarity flips
    for (int i = 0; i < 600; i++) begin
      ceN = ($urandom % 6) == 0;
      if (($urandom % 40) == 0) resetPolInv = ~resetPolInv;
      rstOe = resetPolInv ^ (($urandom % 30) != 0);
      if (($urandom % 25) == 0) begin
        loadEn = 1'b1; loadAddr = ADDR_W'($urandom % DEPTH); loadBit = 1'($urandom & 1);
      end else begin
        loadEn = 1'b0;
      end
      cyc("R3");
    end
    loadEn = 1'b0;

    // R6: power-on reset again after activity
    porRst = 1'b1; cyc("R6");
    porRst = 1'b0; resetPolInv = 1'b0; rstOe = 1'b1; ceN = 1'b0;
    cyc("R6"); cyc("R6");

    finish();
  end

endmodule